// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block carries the message-signalled interrupt logic of a PCI-style endpoint. It keeps a capability message-control register, a vector table of up to 32 entries and a pending-bit array. Each entry holds a 64-bit message address, a 32-bit message data word and a per-vector mask. When the device raises a request on a vector, the block either issues a message write or records the request as pending. The choice depends on whether that vector is currently masked.

Software reaches the block through two ports. The first is a config write port that covers the capability's first dword, with byte enables. The second is a dword register port for the table and the pending array. When a mask is lifted, the block replays pending vectors. A write to a table entry can unmask that vector and release it. A write to the upper control byte that leaves the function enabled and the function mask clear rescans every vector. That same write also pulses a strobe that drops the legacy INTx line.

Messages leave one at a time through a valid/ready port. When several vectors are due at once, the lowest-numbered vector goes first.

Top module: `msix_ctrl`

## Requirements
- R1: After reset, enable and function mask are 0, every vector's mask bit reads 1, no bit is pending and msg_valid is low. The config dword reads {enable[31], function mask[30], 3'b000, table size = NUM_VEC-1 in bits 26:16, next pointer 8'h00, capability ID 8'h11}.
- R2: A config write with cfg_be[3] set loads enable from cfg_wdata[31] and the function mask from cfg_wdata[30]. No other config bit is writable.
- R3: Entry v sits at table byte offset 16*v. Word 0 holds the address low, word 1 the address high, word 2 the data, and bit 0 of word 3 the mask. All of these are read/write, and address bits 1:0 are ignored.
- R4: A request on a vector that is unmasked while enabled and the function mask is clear produces one message carrying that entry's {address high, address low} and data.
- R5: A request while the vector mask is set, the function mask is set, or the enable is clear sets that vector's pending bit and sends nothing. The pending array reads at table address bit TAW (bit 9 for 32 vectors), one bit per vector, and writes there are ignored.
- R6: A table write that leaves its vector unmasked, with the function enabled and unmasked, clears that vector's pending bit and sends its message.
- R7: A config write with cfg_be[3] clear changes no state, produces no strobe and sends nothing.
- R8: A config write with cfg_be[3] set and cfg_wdata[31]=1 pulses intx_deassert for one cycle. If cfg_wdata[30]=0 as well, every unmasked pending vector is cleared and delivered in ascending vector order. A write with cfg_wdata[31]=0 produces no strobe.
- R9: Only one message is outstanding at a time. While msg_valid is high and msg_ready is low, the address and data stay unchanged.
- R10: A request made while a message is waiting is kept and delivered afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe for the capability's first dword |
| cfg_be | input | 4 | Byte enables of the config write |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Current capability dword |
| tbl_wr | input | 1 | Table/pending-array write strobe |
| tbl_addr | input | TAW+1 | Byte address; the top bit selects the pending array |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Read data at tbl_addr (combinational) |
| irq_req | input | NUM_VEC | Per-vector request pulses |
| msg_valid | output | 1 | Message write pending on the output |
| msg_ready | input | 1 | Sink accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| intx_deassert | output | 1 | One-cycle strobe to drop legacy INTx |

## Verification
The bench builds the block with NUM_VEC = 32, the largest table size. This puts the top entry (vector 31), the full 32-bit pending word and the widest table-size field within reach. Its table rows touch vectors 0, 1, 7, 16, 30 and 31, so the lowest and highest index decodes are both exercised. The same build also covers a rescan that must order two releases, and a back-pressured message with a later request queued behind it.

// File: rtl/msix_pkg.sv
// Package: shared constants for the MSI-X vector table controller.
// Assumes 16-byte table entries and dword-granular access.
package msix_pkg;
    localparam logic [7:0] CAP_ID      = 8'h11;
    localparam int         ENTRY_BYTES = 16;
    localparam logic [1:0] W_ADDR_LO   = 2'd0;
    localparam logic [1:0] W_ADDR_HI   = 2'd1;
    localparam logic [1:0] W_DATA      = 2'd2;
    localparam logic [1:0] W_CTRL      = 2'd3;
endpackage

// File: rtl/msix_cfg_reg.sv
// Module: capability message-control register.
// Holds enable and function mask, builds the read-back dword and
// flags control-byte writes that must trigger a rescan.
// Assumes the config port addresses only the capability's first dword.
module msix_cfg_reg
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        en,
    output logic        fmask,
    output logic        scan_go,
    output logic        intx_deassert
);
    localparam logic [10:0] SIZE_FIELD = 11'(NUM_VEC - 1);

    logic lane_hit;

    // Write touches the upper control byte
    assign lane_hit = cfg_wr & cfg_be[3];
    // Rescan when the function stays enabled and unmasked
    assign scan_go  = lane_hit & cfg_wdata[31] & ~cfg_wdata[30];
    // Read-back dword
    assign cfg_rdata = {en, fmask, 3'b000, SIZE_FIELD, 8'h00, CAP_ID};

    // Control bits and INTx strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en            <= 1'b0;
            fmask         <= 1'b0;
            intx_deassert <= 1'b0;
        end else begin
            intx_deassert <= lane_hit & cfg_wdata[31];
            if (lane_hit) begin
                en    <= cfg_wdata[31];
                fmask <= cfg_wdata[30];
            end
        end
    end

    p_nolane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_be[3]) |=> (!intx_deassert && $stable(en) && $stable(fmask)));
    p_intx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intx_deassert |-> $past(en == 1'b0) || en);
endmodule

// File: rtl/msix_vec_table.sv
// Module: vector table storage and register-port decode.
// Stores address/data/mask per entry, serves reads of the table and
// the pending array, and reports which vector a write touched together
// with the mask it leaves behind. Assumes NUM_VEC >= 2.
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int TAW     = 9,
    parameter int VW      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_wr,
    input  logic [TAW:0]       tbl_addr,
    input  logic [31:0]        tbl_wdata,
    input  logic [NUM_VEC-1:0] pend,
    output logic [31:0]        tbl_rdata,
    input  logic [VW-1:0]      sel_idx,
    output logic [63:0]        sel_addr,
    output logic [31:0]        sel_data,
    output logic [NUM_VEC-1:0] vmask_now,
    output logic [NUM_VEC-1:0] vmask_post,
    output logic [NUM_VEC-1:0] wr_touch
);
    logic [31:0] alo [NUM_VEC];
    logic [31:0] ahi [NUM_VEC];
    logic [31:0] dat [NUM_VEC];
    logic        in_pba;
    logic        in_range;
    logic        hit;
    logic [VW-1:0] vec;
    logic [1:0]  word;
    logic [31:0] pba;

    // Address decode, low two bits dropped
    assign in_pba   = tbl_addr[TAW];
    assign vec      = tbl_addr[TAW-1:4];
    assign word     = tbl_addr[3:2];
    assign in_range = (int'(vec) < NUM_VEC);
    assign hit      = tbl_wr & ~in_pba & in_range;

    // Entry storage writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                alo[v]       <= '0;
                ahi[v]       <= '0;
                dat[v]       <= '0;
                vmask_now[v] <= 1'b1;
            end
        end else if (hit) begin
            case (word)
                W_ADDR_LO: alo[vec]       <= tbl_wdata;
                W_ADDR_HI: ahi[vec]       <= tbl_wdata;
                W_DATA:    dat[vec]       <= tbl_wdata;
                default:   vmask_now[vec] <= tbl_wdata[0];
            endcase
        end
    end

    // Per-vector write-touch and post-write mask
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        assign wr_touch[g]   = hit && (int'(vec) == g);
        assign vmask_post[g] = (wr_touch[g] && word == W_CTRL) ? tbl_wdata[0]
                                                                : vmask_now[g];
    end

    // Pending array widened to a dword
    always_comb begin
        pba = '0;
        pba[NUM_VEC-1:0] = pend;
    end

    // Register-port read mux
    always_comb begin
        tbl_rdata = '0;
        if (in_pba) begin
            tbl_rdata = pba;
        end else if (in_range) begin
            case (word)
                W_ADDR_LO: tbl_rdata = alo[vec];
                W_ADDR_HI: tbl_rdata = ahi[vec];
                W_DATA:    tbl_rdata = dat[vec];
                default:   tbl_rdata = {31'd0, vmask_now[vec]};
            endcase
        end
    end

    // Message contents for the engine
    assign sel_addr = {ahi[sel_idx], alo[sel_idx]};
    assign sel_data = dat[sel_idx];

    p_ctrl_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && word == W_CTRL) |=> (vmask_now[$past(vec)] == $past(tbl_wdata[0])));
endmodule

// File: rtl/msix_pick.sv
// Module: lowest-index selector over a request vector.
// Gives a one-hot of the lowest set bit and its binary index.
module msix_pick #(
    parameter int N  = 32,
    parameter int VW = 5
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [N-1:0]  onehot,
    output logic [VW-1:0] idx
);
    // Isolate lowest set bit
    assign onehot = req & (~req + 1'b1);
    assign any    = |req;

    // Encode the isolated bit
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = VW'(i);
        end
    end
endmodule

// File: rtl/msix_ctrl.sv
// Module: MSI-X vector table controller (top).
// Routes requests to message delivery or pending bits, replays pending
// vectors when masks are lifted, and drives one message at a time on a
// valid/ready port, lowest vector first. Queued deliveries are held in
// an internal bit set that software does not see.
module msix_ctrl
    import msix_pkg::*;
#(
    parameter  int NUM_VEC = 32,
    localparam int VW      = $clog2(NUM_VEC),
    localparam int TAW     = VW + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               tbl_wr,
    input  logic [TAW:0]       tbl_addr,
    input  logic [31:0]        tbl_wdata,
    output logic [31:0]        tbl_rdata,
    input  logic [NUM_VEC-1:0] irq_req,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic               intx_deassert
);
    logic               en, fmask, scan_go;
    logic [NUM_VEC-1:0] pend, fire;
    logic [NUM_VEC-1:0] vmask_now, vmask_post, wr_touch;
    logic [NUM_VEC-1:0] masked_now, release_set, pend_mid, fire_add;
    logic [NUM_VEC-1:0] pick_oh;
    logic               pick_any, busy, take;
    logic [VW-1:0]      pick_idx;
    logic [63:0]        sel_addr;
    logic [31:0]        sel_data;

    msix_cfg_reg #(.NUM_VEC(NUM_VEC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .en(en),
        .fmask(fmask), .scan_go(scan_go), .intx_deassert(intx_deassert)
    );

    msix_vec_table #(.NUM_VEC(NUM_VEC), .TAW(TAW), .VW(VW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .pend(pend), .tbl_rdata(tbl_rdata),
        .sel_idx(pick_idx), .sel_addr(sel_addr), .sel_data(sel_data),
        .vmask_now(vmask_now), .vmask_post(vmask_post), .wr_touch(wr_touch)
    );

    msix_pick #(.N(NUM_VEC), .VW(VW)) u_pick (
        .req(fire), .any(pick_any), .onehot(pick_oh), .idx(pick_idx)
    );

    // Effective mask seen by a new request
    assign masked_now = vmask_now | {NUM_VEC{fmask | ~en}};

    // Vectors whose mask is lifted this cycle
    always_comb begin
        release_set = '0;
        if (en && !fmask) release_set = wr_touch & ~vmask_post;
        if (scan_go)      release_set = release_set | ~vmask_post;
    end

    // Route requests, then move released pending bits to delivery
    assign pend_mid = pend | (irq_req & masked_now);
    assign fire_add = (irq_req & ~masked_now) | (pend_mid & release_set);
    assign take     = !busy && pick_any;

    // Pending and delivery bit sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            fire <= '0;
        end else begin
            pend <= pend_mid & ~release_set;
            fire <= (fire & ~(take ? pick_oh : '0)) | fire_add;
        end
    end

    // Single-message output engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            msg_addr <= '0;
            msg_data <= '0;
        end else if (take) begin
            busy     <= 1'b1;
            msg_addr <= sel_addr;
            msg_data <= sel_data;
        end else if (busy && msg_ready) begin
            busy <= 1'b0;
        end
    end

    assign msg_valid = busy;

    p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pick_any) |=> msg_valid);
    p_msg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
    p_req_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |=> (((pend | fire) & $past(irq_req)) == $past(irq_req)));
    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & masked_now) != '0 && release_set == '0) |=>
            ((pend & $past(irq_req & masked_now)) == $past(irq_req & masked_now)));
endmodule

// File: tb/sim_msix_ctrl.sv
module sim_msix_ctrl;
    localparam int N   = 32;
    localparam int TAW = 9;

    typedef struct packed {
        logic [4:0]  vec;
        logic [31:0] alo;
        logic [31:0] ahi;
        logic [31:0] dat;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{5'd0,  32'h0000_1000, 32'h0000_0000, 32'h0000_00A0},
        '{5'd1,  32'h0000_1010, 32'h0000_0001, 32'h0000_00A1},
        '{5'd7,  32'hFEE0_0070, 32'h0000_0000, 32'h1234_0007},
        '{5'd16, 32'h8000_0100, 32'hABCD_0000, 32'h5555_0016},
        '{5'd30, 32'h0000_0ABC, 32'h0000_00FF, 32'hDEAD_0030},
        '{5'd31, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'hC0DE_0031}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [3:0]    cfg_be = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          tbl_wr = 1'b0;
    logic [TAW:0]  tbl_addr = '0;
    logic [31:0]   tbl_wdata = '0;
    logic [31:0]   tbl_rdata;
    logic [N-1:0]  irq_req = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;
    logic          intx_deassert;

    int checks = 0;
    int errors = 0;

    msix_ctrl #(.NUM_VEC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tbl_wr(tbl_wr),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
        .irq_req(irq_req), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data), .intx_deassert(intx_deassert)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [TAW:0] ta(input int vec, input int word);
        return (TAW+1)'(vec * 16 + word * 4);
    endfunction

    localparam logic [TAW:0] PBA = (TAW+1)'(1 << TAW);

    task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic tbl_write(input logic [TAW:0] a, input logic [31:0] d);
        tbl_wr = 1'b1; tbl_addr = a; tbl_wdata = d;
        @(posedge clk); @(negedge clk);
        tbl_wr = 1'b0;
    endtask

    task automatic tbl_read(input logic [TAW:0] a, output logic [31:0] d);
        tbl_addr = a; #1; d = tbl_rdata;
    endtask

    task automatic irq(input int v);
        irq_req[v] = 1'b1;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic wait_msg(output bit got, output logic [63:0] a, output logic [31:0] d);
        got = 1'b0; a = '0; d = '0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (msg_valid) begin
                got = 1'b1; a = msg_addr; d = msg_data;
                msg_ready = 1'b1;
                @(negedge clk);
                msg_ready = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (msg_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, req, 64'(seen), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit got;
        logic [63:0] a;
        logic [31:0] d;
        logic [63:0] a_hold;
        logic [31:0] d_hold;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cfg_rdata == 32'h001F_0011, "R1 cfg dword", 64'(cfg_rdata), 64'h001F_0011);
        tbl_read(ta(0, 3), d);
        chk(d == 32'd1, "R1 vec0 masked", 64'(d), 64'd1);
        tbl_read(ta(31, 3), d);
        chk(d == 32'd1, "R1 vec31 masked", 64'(d), 64'd1);
        tbl_read(PBA, d);
        chk(d == 32'd0, "R1 pending clear", 64'(d), 64'd0);
        chk(!msg_valid, "R1 msg_valid low", 64'(msg_valid), 64'd0);

        // R7 lanes 0..2 only: nothing changes
        cfg_write(4'b0111, 32'hFFFF_FFFF);
        chk(!intx_deassert, "R7 no strobe", 64'(intx_deassert), 64'd0);
        chk(cfg_rdata == 32'h001F_0011, "R7 cfg unchanged", 64'(cfg_rdata), 64'h001F_0011);

        // R2 upper byte writes enable and function mask only
        cfg_write(4'b1000, 32'hFFFF_FFFF);
        chk(cfg_rdata == 32'hC01F_0011, "R2 en+fmask set", 64'(cfg_rdata), 64'hC01F_0011);
        cfg_write(4'b1000, 32'h8000_0000);
        chk(cfg_rdata == 32'h801F_0011, "R2 en only", 64'(cfg_rdata), 64'h801F_0011);

        // R3 entry access ignoring low address bits
        tbl_write(ta(5, 0) | 3, 32'hDEAD_BEE0);
        tbl_read(ta(5, 0) | 1, d);
        chk(d == 32'hDEAD_BEE0, "R3 addr lo rw", 64'(d), 64'hDEAD_BEE0);

        // R4 vector table walk: program, unmask, request, expect message
        foreach (ROWS[k]) begin
            tbl_write(ta(ROWS[k].vec, 0), ROWS[k].alo);
            tbl_write(ta(ROWS[k].vec, 1), ROWS[k].ahi);
            tbl_write(ta(ROWS[k].vec, 2), ROWS[k].dat);
            tbl_write(ta(ROWS[k].vec, 3), 32'd0);
            irq(ROWS[k].vec);
            wait_msg(got, a, d);
            chk(got && a == {ROWS[k].ahi, ROWS[k].alo}, "R4 msg addr", a,
                {ROWS[k].ahi, ROWS[k].alo});
            chk(got && d == ROWS[k].dat, "R4 msg data", 64'(d), 64'(ROWS[k].dat));
        end

        // R5 masked vector request goes pending; pending array read-only
        tbl_write(ta(3, 0), 32'h0000_3000);
        tbl_write(ta(3, 2), 32'h0000_0333);
        irq(3);
        quiet(5, "R5 masked no msg");
        tbl_read(PBA, d);
        chk(d == 32'h8, "R5 pending bit3", 64'(d), 64'h8);
        tbl_write(PBA, 32'h0);
        tbl_read(PBA, d);
        chk(d == 32'h8, "R5 pending write ignored", 64'(d), 64'h8);

        // R6 unmasking write releases the pending vector
        tbl_write(ta(3, 3), 32'd0);
        wait_msg(got, a, d);
        chk(got && a == 64'h3000 && d == 32'h333, "R6 replay msg", a, 64'h3000);
        tbl_read(PBA, d);
        chk(d == 32'd0, "R6 pending cleared", 64'(d), 64'd0);

        // R5 function mask holds requests; R7 then R8 rescan
        cfg_write(4'b1000, 32'hC000_0000);
        chk(intx_deassert, "R8 strobe with fmask", 64'(intx_deassert), 64'd1);
        irq(1);
        irq(0);
        quiet(4, "R5 fmask no msg");
        tbl_read(PBA, d);
        chk(d == 32'h3, "R5 fmask pending", 64'(d), 64'h3);
        cfg_write(4'b0111, 32'h0000_0000);
        chk(!intx_deassert, "R7 no strobe 2", 64'(intx_deassert), 64'd0);
        quiet(4, "R7 no release");
        cfg_write(4'b1000, 32'h8000_0000);
        chk(intx_deassert, "R8 strobe", 64'(intx_deassert), 64'd1);
        wait_msg(got, a, d);
        chk(got && d == 32'hA0, "R8 first vec0", 64'(d), 64'hA0);
        wait_msg(got, a, d);
        chk(got && d == 32'hA1, "R8 second vec1", 64'(d), 64'hA1);
        tbl_read(PBA, d);
        chk(d == 32'd0, "R8 pending cleared", 64'(d), 64'd0);

        // R5 disabled function; R8 no strobe when disabling
        cfg_write(4'b1000, 32'h0000_0000);
        chk(!intx_deassert, "R8 no strobe on disable", 64'(intx_deassert), 64'd0);
        irq(7);
        quiet(4, "R5 disabled no msg");
        tbl_read(PBA, d);
        chk(d == 32'h80, "R5 disabled pending", 64'(d), 64'h80);
        cfg_write(4'b1000, 32'h8000_0000);
        wait_msg(got, a, d);
        chk(got && d == 32'h1234_0007, "R8 release vec7", 64'(d), 64'h1234_0007);

        // R9 hold under back-pressure; R10 queued request
        irq(16);
        for (int i = 0; i < 10 && !msg_valid; i++) @(negedge clk);
        a_hold = msg_addr; d_hold = msg_data;
        irq(30);
        repeat (4) @(negedge clk);
        chk(msg_valid && msg_addr == a_hold && msg_data == d_hold, "R9 held stable",
            msg_addr, a_hold);
        chk(d_hold == 32'h5555_0016, "R9 vec16 data", 64'(d_hold), 64'h5555_0016);
        wait_msg(got, a, d);
        wait_msg(got, a, d);
        chk(got && d == 32'hDEAD_0030, "R10 queued vec30", 64'(d), 64'hDEAD_0030);
        quiet(4, "R9 single delivery");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule